// File: doc/BRIEF.md
# Prefixed Vector-Loop Program Counter Sequencer

This block computes the next instruction address for a 64-bit core whose instructions may carry an optional 32-bit vector prefix. The fetch stage presents the first word at the current address. The sequencer classifies that word as a prefix or a plain instruction and reports where the real operation word sits. When the execute stage signals completion, the sequencer registers the address the fetch stage should use next.

For prefixed instructions the sequencer also runs an element loop. The same instruction is issued again at an unchanged address, once per vector element, and a 7-bit element step counts through the elements. The loop ends at the last element. It also ends after a single pass when the destination is scalar. A vector length of zero turns the instruction into a no-op that is stepped over. A trap redirect overrides everything: it loads the trap entry point and abandons any loop in progress.

Top module: `vloop_pc_seq`

## Requirements
- R1: A fetched word is a prefix only if its top six bits [31:26] equal 6'b000001, bit 24 is 1 and bit 22 is 1. These are bits 0-5, 7 and 9 counted from the most significant end. A word that misses any one of these conditions is a plain instruction.
- R2: On a completion strobe for a plain instruction, with no trap, the next address becomes the current address + 4 and the element step becomes 0.
- R3: When a prefixed instruction finishes its loop, the next address becomes the current address + 8.
- R4: `suffix_addr` always equals the current address + 4. This is where the operation word of a prefixed instruction is fetched.
- R5: `skip` is 1 exactly when the word is a prefix and the vector length is 0. A completion strobe in that state advances the address by 8 and leaves the step at 0.
- R6: On a completion strobe for a prefixed instruction with a vector destination, vector length VL ≥ 1 and step ≠ VL-1, the step increments by 1 and the next address equals the current address.
- R7: On a completion strobe for a prefixed instruction where step = VL-1, the step returns to 0 and the address advances by 8.
- R8: When the destination is flagged scalar, a prefixed instruction ends after one pass: the step stays 0 and the address advances by 8.
- R9: A trap request loads the next address with the trap base + 0x700 and clears the step. It acts with or without a completion strobe and has priority over the loop and over normal advance.
- R10: Without a completion strobe or trap request, the next address and the step hold their values.
- R11: Synchronous active-high reset loads the next address with the reset address (default 0x1000) and clears the step.
- R12: The step is 7 bits wide, so a vector length of 127 gives 127 passes, with steps 0 to 126, before the address advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_addr | input | 64 | Address of the instruction being executed |
| fetch_word | input | 32 | First word fetched at cur_addr |
| vec_len | input | 7 | Current vector length |
| exec_done | input | 1 | One-cycle completion strobe from execute |
| dst_scalar | input | 1 | Destination of the instruction is scalar |
| trap_req | input | 1 | Trap redirect request |
| trap_base | input | 64 | Base address for the trap vector |
| nxt_addr | output | 64 | Registered next instruction address |
| elem_step | output | 7 | Registered element step |
| is_prefixed | output | 1 | fetch_word is a prefix |
| suffix_addr | output | 64 | Address of the operation word (cur_addr + 4) |
| skip | output | 1 | Prefixed instruction with zero vector length |

## Verification
A step register that is one too high, or that fails to clear, shows at the ports on the next completion strobe. The loop then ends one pass early or late, and `nxt_addr` advances at the wrong strobe. A wrong prefix classification shows at once on `is_prefixed` and `skip`, and one strobe later as a +4/+8 mismatch. Trap priority errors show in the cycle after the request, as a next address other than base + 0x700 or a step that is not zero. Loops of lengths 1, 4, 5 and 127, as well as scalar and zero-length cases, pin every loop exit on the exact strobe.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
    localparam int WORD_W    = 32;
    localparam int MAJOR_W   = 6;
    localparam logic [MAJOR_W-1:0] MAJOR_PFX = 6'b000001;
    localparam int MARK_A_MSB0 = 7;
    localparam int MARK_B_MSB0 = 9;
    localparam int MARK_A_POS  = WORD_W - 1 - MARK_A_MSB0;
    localparam int MARK_B_POS  = WORD_W - 1 - MARK_B_MSB0;
    localparam int SEQ_INC   = 4;
    localparam int PFX_INC   = 8;

    typedef enum logic [1:0] {
        ADV_SEQ  = 2'd0,
        ADV_PFX  = 2'd1,
        ADV_HOLD = 2'd2,
        ADV_TRAP = 2'd3
    } adv_e;
endpackage

// File: rtl/vloop_pfx_decode.sv
module vloop_pfx_decode
    import vloop_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_pfx
);
    logic [MAJOR_W-1:0] major;
    always_comb begin
        major  = word[WORD_W-1 -: MAJOR_W];
        is_pfx = (major == MAJOR_PFX) && word[MARK_A_POS] && word[MARK_B_POS];
    end
endmodule

// File: rtl/vloop_step_ctl.sv
module vloop_step_ctl
    import vloop_pkg::*;
#(
    parameter int STEP_W = 7
) (
    input  logic              trap,
    input  logic              is_pfx,
    input  logic              dst_scalar,
    input  logic [STEP_W-1:0] vl,
    input  logic [STEP_W-1:0] step,
    output adv_e              adv,
    output logic [STEP_W-1:0] step_nxt,
    output logic              skip
);
    logic last;
    always_comb begin
        skip = is_pfx && (vl == '0);
        last = (step == vl - STEP_W'(1));
        if (trap) begin
            adv      = ADV_TRAP;
            step_nxt = '0;
        end else if (!is_pfx) begin
            adv      = ADV_SEQ;
            step_nxt = '0;
        end else if (skip || dst_scalar || last) begin
            adv      = ADV_PFX;
            step_nxt = '0;
        end else begin
            adv      = ADV_HOLD;
            step_nxt = step + STEP_W'(1);
        end
    end
endmodule

// File: rtl/vloop_addr_gen.sv
module vloop_addr_gen
    import vloop_pkg::*;
#(
    parameter int              ADDR_W   = 64,
    parameter logic [ADDR_W-1:0] TRAP_OFS = 'h700
) (
    input  adv_e              adv,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] trap_base,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (adv)
            ADV_SEQ:  addr = cur + ADDR_W'(SEQ_INC);
            ADV_PFX:  addr = cur + ADDR_W'(PFX_INC);
            ADV_HOLD: addr = cur;
            default:  addr = trap_base + TRAP_OFS;
        endcase
    end
endmodule

// File: rtl/vloop_pc_seq.sv
module vloop_pc_seq
    import vloop_pkg::*;
#(
    parameter int                ADDR_W     = 64,
    parameter int                STEP_W     = 7,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h1000,
    parameter logic [ADDR_W-1:0] TRAP_OFS   = 'h700
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [STEP_W-1:0] vec_len,
    input  logic              exec_done,
    input  logic              dst_scalar,
    input  logic              trap_req,
    input  logic [ADDR_W-1:0] trap_base,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [STEP_W-1:0] elem_step,
    output logic              is_prefixed,
    output logic [ADDR_W-1:0] suffix_addr,
    output logic              skip
);
    adv_e              adv;
    logic [STEP_W-1:0] step_d;
    logic [ADDR_W-1:0] addr_d;

    vloop_pfx_decode u_dec (
        .word   (fetch_word),
        .is_pfx (is_prefixed)
    );

    vloop_step_ctl #(.STEP_W(STEP_W)) u_step (
        .trap       (trap_req),
        .is_pfx     (is_prefixed),
        .dst_scalar (dst_scalar),
        .vl         (vec_len),
        .step       (elem_step),
        .adv        (adv),
        .step_nxt   (step_d),
        .skip       (skip)
    );

    vloop_addr_gen #(.ADDR_W(ADDR_W), .TRAP_OFS(TRAP_OFS)) u_addr (
        .adv       (adv),
        .cur       (cur_addr),
        .trap_base (trap_base),
        .addr      (addr_d)
    );

    assign suffix_addr = cur_addr + ADDR_W'(SEQ_INC);

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_addr  <= RESET_ADDR;
            elem_step <= '0;
        end else if (trap_req || exec_done) begin
            nxt_addr  <= addr_d;
            elem_step <= step_d;
        end
    end
endmodule

// File: rtl/vloop_pc_seq_chk.sv
module vloop_pc_seq_chk #(
    parameter int                ADDR_W   = 64,
    parameter int                STEP_W   = 7,
    parameter logic [ADDR_W-1:0] TRAP_OFS = 'h700
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [STEP_W-1:0] vec_len,
    input logic              exec_done,
    input logic              dst_scalar,
    input logic              trap_req,
    input logic [ADDR_W-1:0] trap_base,
    input logic [ADDR_W-1:0] nxt_addr,
    input logic [STEP_W-1:0] elem_step,
    input logic              is_prefixed,
    input logic              skip
);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!exec_done && !trap_req) |=> ($stable(nxt_addr) && $stable(elem_step)));

    p_trap_r9: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (elem_step == '0 && nxt_addr == $past(trap_base) + TRAP_OFS));

    p_plain_r2: assert property (@(posedge clk) disable iff (rst)
        (exec_done && !trap_req && !is_prefixed) |=>
            (elem_step == '0 && nxt_addr == $past(cur_addr) + ADDR_W'(4)));

    p_scalar_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_done && !trap_req && is_prefixed && dst_scalar) |=>
            (elem_step == '0 && nxt_addr == $past(cur_addr) + ADDR_W'(8)));

    p_skip_r5: assert property (@(posedge clk) disable iff (rst)
        skip |-> (is_prefixed && vec_len == '0));

    p_loop_r6: assert property (@(posedge clk) disable iff (rst)
        (exec_done && !trap_req && is_prefixed && !dst_scalar && vec_len != '0
         && elem_step != vec_len - STEP_W'(1)) |=>
            (nxt_addr == $past(cur_addr) && elem_step == $past(elem_step) + STEP_W'(1)));
endmodule

bind vloop_pc_seq vloop_pc_seq_chk #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .TRAP_OFS(TRAP_OFS)
) u_chk (
    .clk(clk), .rst(rst), .cur_addr(cur_addr), .vec_len(vec_len),
    .exec_done(exec_done), .dst_scalar(dst_scalar), .trap_req(trap_req),
    .trap_base(trap_base), .nxt_addr(nxt_addr), .elem_step(elem_step),
    .is_prefixed(is_prefixed), .skip(skip)
);

// File: tb/tb_vloop_pc_seq.sv
`timescale 1ns/1ps
module tb_vloop_pc_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cur_addr;
    logic [31:0] fetch_word;
    logic [6:0]  vec_len;
    logic        exec_done;
    logic        dst_scalar;
    logic        trap_req;
    logic [63:0] trap_base;
    logic [63:0] nxt_addr;
    logic [6:0]  elem_step;
    logic        is_prefixed;
    logic [63:0] suffix_addr;
    logic        skip;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    vloop_pc_seq dut (
        .clk(clk), .rst(rst), .cur_addr(cur_addr), .fetch_word(fetch_word),
        .vec_len(vec_len), .exec_done(exec_done), .dst_scalar(dst_scalar),
        .trap_req(trap_req), .trap_base(trap_base), .nxt_addr(nxt_addr),
        .elem_step(elem_step), .is_prefixed(is_prefixed),
        .suffix_addr(suffix_addr), .skip(skip)
    );

    localparam logic [31:0] PW = 32'h0540_0000;   // prefix word
    localparam logic [31:0] AW = 32'h3800_0000;   // plain operation

    typedef struct packed {
        logic [63:0] cur;
        logic [31:0] word;
        logic [6:0]  vl;
        logic        scal;
        logic        trap;
        logic [63:0] tbase;
        logic [63:0] e_nxt;
        logic [6:0]  e_step;
        logic        e_skip;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{64'h1000, AW,           7'd0, 1'b0, 1'b0, 64'h0, 64'h1004, 7'd0, 1'b0, 4'd2},  // R2
        '{64'h1004, 32'h0400_0000, 7'd0, 1'b0, 1'b0, 64'h0, 64'h1008, 7'd0, 1'b0, 4'd1}, // R1 marks missing
        '{64'h1008, 32'h0500_0000, 7'd0, 1'b0, 1'b0, 64'h0, 64'h100C, 7'd0, 1'b0, 4'd1}, // R1 bit 9 missing
        '{64'h100C, 32'h0440_0000, 7'd0, 1'b0, 1'b0, 64'h0, 64'h1010, 7'd0, 1'b0, 4'd1}, // R1 bit 7 missing
        '{64'h2000, PW, 7'd0, 1'b0, 1'b0, 64'h0, 64'h2008, 7'd0, 1'b1, 4'd5},           // R5 zero length
        '{64'h2008, PW, 7'd1, 1'b0, 1'b0, 64'h0, 64'h2010, 7'd0, 1'b0, 4'd7},           // R7 VL=1
        '{64'h2010, PW, 7'd5, 1'b0, 1'b0, 64'h0, 64'h2010, 7'd1, 1'b0, 4'd6},           // R6
        '{64'h2010, PW, 7'd5, 1'b0, 1'b0, 64'h0, 64'h2010, 7'd2, 1'b0, 4'd6},
        '{64'h2010, PW, 7'd5, 1'b0, 1'b0, 64'h0, 64'h2010, 7'd3, 1'b0, 4'd6},
        '{64'h2010, PW, 7'd5, 1'b0, 1'b0, 64'h0, 64'h2010, 7'd4, 1'b0, 4'd6},
        '{64'h2010, PW, 7'd5, 1'b0, 1'b0, 64'h0, 64'h2018, 7'd0, 1'b0, 4'd3},           // R3 loop end
        '{64'h2018, PW, 7'd5, 1'b1, 1'b0, 64'h0, 64'h2020, 7'd0, 1'b0, 4'd8},           // R8 scalar
        '{64'h2020, PW, 7'd4, 1'b0, 1'b0, 64'h0, 64'h2020, 7'd1, 1'b0, 4'd6},
        '{64'h2020, PW, 7'd4, 1'b0, 1'b0, 64'h0, 64'h2020, 7'd2, 1'b0, 4'd6},
        '{64'h2020, PW, 7'd4, 1'b0, 1'b1, 64'h0, 64'h0700, 7'd0, 1'b0, 4'd9},           // R9 mid-loop trap
        '{64'h3000, AW, 7'd0, 1'b0, 1'b1, 64'h8000_0000, 64'h8000_0700, 7'd0, 1'b0, 4'd9}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input bit strobe);
        @(negedge clk);
        cur_addr   = v.cur;
        fetch_word = v.word;
        vec_len    = v.vl;
        dst_scalar = v.scal;
        trap_req   = v.trap;
        trap_base  = v.tbase;
        exec_done  = strobe;
        #1;
        check(skip == v.e_skip, "R5 skip", 64'(skip), 64'(v.e_skip));
        check(suffix_addr == v.cur + 64'd4, "R4 suffix", suffix_addr, v.cur + 64'd4);
        @(negedge clk);
        exec_done = 1'b0;
        trap_req  = 1'b0;
        check(nxt_addr == v.e_nxt, $sformatf("R%0d next", v.req), nxt_addr, v.e_nxt);
        check(elem_step == v.e_step, $sformatf("R%0d step", v.req), 64'(elem_step), 64'(v.e_step));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        vec_t v;
        rst = 1'b1; cur_addr = '0; fetch_word = AW; vec_len = '0;
        exec_done = 0; dst_scalar = 0; trap_req = 0; trap_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(nxt_addr == 64'h1000, "R11 reset addr", nxt_addr, 64'h1000);
        check(elem_step == 7'd0, "R11 reset step", 64'(elem_step), 64'd0);
        // R1 classification of the prefix pattern
        fetch_word = PW; #1;
        check(is_prefixed == 1'b1, "R1 prefix seen", 64'(is_prefixed), 64'd1);
        fetch_word = 32'h0540_0001 ^ 32'h0000_0001 ^ 32'h0C00_0000; #1;
        check(is_prefixed == 1'b0, "R1 major mismatch", 64'(is_prefixed), 64'd0);

        for (int i = 0; i < NV; i++) drive(VT[i], 1'b1);

        // R10 hold without strobe
        v = '{64'h5000, PW, 7'd3, 1'b0, 1'b0, 64'h0, 64'h8000_0700, 7'd0, 1'b0, 4'd10};
        drive(v, 1'b0);
        repeat (3) @(negedge clk);
        check(nxt_addr == 64'h8000_0700, "R10 hold addr", nxt_addr, 64'h8000_0700);

        // R9 trap alone, no strobe, during a loop
        v = '{64'h6000, PW, 7'd3, 1'b0, 1'b0, 64'h0, 64'h6000, 7'd1, 1'b0, 4'd6};
        drive(v, 1'b1);
        v = '{64'h6000, PW, 7'd3, 1'b0, 1'b1, 64'h4000, 64'h4700, 7'd0, 1'b0, 4'd9};
        drive(v, 1'b0);

        // R11 reset mid-loop
        v = '{64'h6000, PW, 7'd3, 1'b0, 1'b0, 64'h0, 64'h6000, 7'd1, 1'b0, 4'd6};
        drive(v, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(nxt_addr == 64'h1000, "R11 reset mid-loop addr", nxt_addr, 64'h1000);
        check(elem_step == 7'd0, "R11 reset mid-loop step", 64'(elem_step), 64'd0);

        // R12 full-width loop: VL=127
        for (int k = 1; k <= 126; k++) begin
            v = '{64'h7000, PW, 7'd127, 1'b0, 1'b0, 64'h0, 64'h7000, 7'(k), 1'b0, 4'd12};
            drive(v, 1'b1);
        end
        v = '{64'h7000, PW, 7'd127, 1'b0, 1'b0, 64'h0, 64'h7008, 7'd0, 1'b0, 4'd12};
        drive(v, 1'b1);

        finish_run();
    end
endmodule